// File: doc/BRIEF.md
# Master-Clocked Two-Channel Serial Readout

This block sends two stored 16-bit conversion results as one 32-bit serial frame. It generates its own serial clock by dividing the system clock, and it drives a frame-sync line. A start request loads both results into a shift register. The bits then go out most significant bit first, in the channel order that the order select picks. The sync line is active for the whole frame except for one serial-clock period. That inactive period marks the point where the second channel begins. A polarity select inverts the sync line.

A read-mode select decides when a frame may launch. In the during-conversion mode, a start request launches a frame at once, even while a conversion is running, so the results already held go out. In the after-conversion mode, a request that arrives while the busy indication is high is held. The frame then launches on the first cycle after busy goes low. A start request that arrives while a frame is running is ignored.

Top module: `mclk_frame_reader`

## Requirements
- R1: While reset is held low and right after it, `sclk_o` is 0, `sdata_o` is 0 and `sync_o` is at its idle level. The idle level is 0 when `sync_inv` is 0.
- R2: A frame carries 32 bits, most significant bit first. With `order_sel`=0 the frame is {chan_a_data, chan_b_data}. With `order_sel`=1 it is {chan_b_data, chan_a_data}.
- R3: Each bit lasts CLK_DIV system cycles. `sclk_o` is high in phases 1 through CLK_DIV/2 of each bit period and low in the other phases. `sclk_o` is 0 whenever no frame is running.
- R4: `sdata_o` changes only at the start of a bit period. It is therefore stable on both the rising and the falling edge of `sclk_o`.
- R5: With `sync_inv`=0, `sync_o` is 1 during bits 0..15 and 17..31 of a frame, 0 during bit 16 (one serial-clock period), and 0 between frames.
- R6: With `sync_inv`=1, `sync_o` is the exact inverse of R5: it idles at 1 and is 1 during bit 16.
- R7: With `read_mode`=1, a start request seen at a clock edge launches the frame on that edge, even while `conv_busy` is 1. Bit 0 is presented in the following cycle.
- R8: With `read_mode`=0, a start request made while `conv_busy` is 1 is held, and no frame is sent. The frame launches on the first edge at which `conv_busy` is 0.
- R9: A start request that arrives while a frame is running has no effect. No extra frame follows.
- R10: Both results are captured when the frame launches. Changing `chan_a_data` or `chan_b_data` during a frame does not alter the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_a_data | input | SAMPLE_W | Result of channel A |
| chan_b_data | input | SAMPLE_W | Result of channel B |
| order_sel | input | 1 | 0: channel A first, 1: channel B first |
| sync_inv | input | 1 | Frame-sync polarity select |
| read_mode | input | 1 | 1: may send during a conversion, 0: only after it |
| conv_busy | input | 1 | High while a conversion is running |
| start_req | input | 1 | Request to send one frame |
| sclk_o | output | 1 | Generated serial clock |
| sdata_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame sync with channel-boundary pulse |

## Verification
The bench checks the exact cycle in which each frame launches. A design that let a request slip through while busy in the after-conversion mode would launch a frame early. A design that dropped the held request would never send it. Both show up as a wrong or missing start cycle. The boundary pulse is checked bit by bit in both polarities, so an off-by-one boundary or a pulse that lasts the wrong length is caught. The bench also checks data stability across both serial-clock edges and a mid-frame restart request. A design that restarted the frame, or queued a second one, would show a truncated frame or a frame that nothing requested. Changing the inputs mid-frame exposes a design that reads them live instead of capturing them.

// File: rtl/mfr_pkg.sv
// Shared types for the master-clocked frame reader.
// Assumes: one-bit mode selects arrive as plain logic and are cast here.
package mfr_pkg;

    typedef enum logic {
        ORD_A_FIRST = 1'b0,
        ORD_B_FIRST = 1'b1
    } chan_order_e;

    typedef enum logic {
        RD_AFTER_CONV  = 1'b0,
        RD_DURING_CONV = 1'b1
    } read_mode_e;

    // True when the read mode allows a frame to launch given the busy flag.
    function automatic logic launch_allowed(read_mode_e mode, logic busy);
        return (mode == RD_DURING_CONV) || !busy;
    endfunction

endpackage

// File: rtl/mfr_start_ctrl.sv
// Decides when a frame launches.
// A request made while idle either launches at once or, in the
// after-conversion mode with busy high, is held until busy drops.
// Requests made while a frame runs are dropped.
// Assumes: frame_on comes from the bit timer and is low on the cycle launch fires.
module mfr_start_ctrl
    import mfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       conv_busy,
    input  read_mode_e mode,
    input  logic       frame_on,
    output logic       launch
);

    logic pending;
    logic wants_frame;

    // A frame is wanted when idle and a request is new or held.
    assign wants_frame = !frame_on && (start_req || pending);
    assign launch      = wants_frame && launch_allowed(mode, conv_busy);

    // Hold a request that could not launch yet; clear it on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (launch) begin
            pending <= 1'b0;
        end else if (start_req && !frame_on) begin
            pending <= 1'b1;
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && conv_busy && mode == RD_AFTER_CONV) |=> !frame_on); // R8

    AST_IGNORE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && frame_on && !pending) |=> !pending); // R9

endmodule

// File: rtl/mfr_bit_timer.sv
// Generates the frame timing.
// It divides the system clock into bit periods, counts the bits, shapes the
// serial clock and gives the active window of the frame sync.
// Assumes: CLK_DIV is even and at least 4, so both serial clock edges fall
// strictly inside a bit period.
module mfr_bit_timer #(
    parameter int FRAME_BITS = 32,
    parameter int BOUNDARY   = 16,
    parameter int CLK_DIV    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic frame_on,
    output logic bit_adv,
    output logic sclk,
    output logic sync_act
);

    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam int HALF  = CLK_DIV / 2;

    logic [CNT_W-1:0] div_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             frame_q;
    logic             period_end;
    logic             last_bit;

    assign period_end = frame_q && (div_cnt == CNT_W'(CLK_DIV - 1));
    assign last_bit   = (bit_idx == IDX_W'(FRAME_BITS - 1));

    // Advance the phase counter and the bit index; end after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (launch) begin
            frame_q <= 1'b1;
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (frame_q) begin
            if (period_end) begin
                div_cnt <= '0;
                if (last_bit) begin
                    frame_q <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign frame_on = frame_q;
    assign bit_adv  = period_end;
    assign sclk     = frame_q && (div_cnt != '0) && (div_cnt <= CNT_W'(HALF));
    assign sync_act = frame_q && (bit_idx != IDX_W'(BOUNDARY));

    AST_FRAME_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_q) |-> ($past(bit_idx) == IDX_W'(FRAME_BITS - 1))); // R2

endmodule

// File: rtl/mfr_shift_out.sv
// Holds the frame word and shifts it out MSB first.
// Zeros are shifted in behind the data, so the line rests at 0 after a frame.
// Assumes: load and shift are never high together.
module mfr_shift_out #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic [FRAME_BITS-1:0] load_word,
    output logic                  sdata
);

    logic [FRAME_BITS-1:0] sreg;

    // Capture the word on load, otherwise move one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_word;
        end else if (shift) begin
            sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign sdata = sreg[FRAME_BITS-1];

    AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdata == $past(load_word[FRAME_BITS-1]))); // R10

endmodule

// File: rtl/mclk_frame_reader.sv
// Top of the master-clocked two-channel serial readout.
// It orders the two results into one frame and drives the serial clock,
// the data line and the polarity-selectable frame sync.
// Assumes: sync_inv and order_sel change only between frames.
module mclk_frame_reader #(
    parameter int SAMPLE_W = 16,
    parameter int CLK_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] chan_a_data,
    input  logic [SAMPLE_W-1:0] chan_b_data,
    input  logic                order_sel,
    input  logic                sync_inv,
    input  logic                read_mode,
    input  logic                conv_busy,
    input  logic                start_req,
    output logic                sclk_o,
    output logic                sdata_o,
    output logic                sync_o
);
    import mfr_pkg::*;

    localparam int FRAME_BITS = 2 * SAMPLE_W;

    logic                  launch;
    logic                  frame_on;
    logic                  bit_adv;
    logic                  sclk_int;
    logic                  sync_act;
    logic [FRAME_BITS-1:0] frame_word;
    chan_order_e           order;
    read_mode_e            mode;

    assign order = chan_order_e'(order_sel);
    assign mode  = read_mode_e'(read_mode);

    // Put the selected channel in the upper half of the frame word.
    always_comb begin
        if (order == ORD_B_FIRST) begin
            frame_word = {chan_b_data, chan_a_data};
        end else begin
            frame_word = {chan_a_data, chan_b_data};
        end
    end

    mfr_start_ctrl u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .conv_busy (conv_busy),
        .mode      (mode),
        .frame_on  (frame_on),
        .launch    (launch)
    );

    mfr_bit_timer #(
        .FRAME_BITS (FRAME_BITS),
        .BOUNDARY   (SAMPLE_W),
        .CLK_DIV    (CLK_DIV)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .frame_on (frame_on),
        .bit_adv  (bit_adv),
        .sclk     (sclk_int),
        .sync_act (sync_act)
    );

    mfr_shift_out #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .shift     (bit_adv),
        .load_word (frame_word),
        .sdata     (sdata_o)
    );

    assign sclk_o = sclk_int;
    assign sync_o = sync_act ^ sync_inv;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |-> !sclk_o); // R3

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_on && $past(frame_on) && !$past(bit_adv)) |-> $stable(sdata_o)); // R4

    AST_SYNC_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |-> (sync_o == sync_inv)); // R5 R6

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_on) |-> !sdata_o); // R1

endmodule

// File: tb/mclk_frame_reader_tb_top.sv
module mclk_frame_reader_tb_top;

    localparam int SW  = 16;
    localparam int DIV = 4;
    localparam int FB  = 2 * SW;

    typedef struct {
        logic [FB-1:0] word;
        int            start;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] chan_a = '0;
    logic [SW-1:0] chan_b = '0;
    logic          order_sel = 1'b0;
    logic          sync_inv = 1'b0;
    logic          read_mode = 1'b1;
    logic          conv_busy = 1'b0;
    logic          start_req = 1'b0;
    logic          sclk_o;
    logic          sdata_o;
    logic          sync_o;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   frames_seen = 0;
    int   frames_pushed = 0;
    logic mon_busy = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    mclk_frame_reader #(.SAMPLE_W(SW), .CLK_DIV(DIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_a_data (chan_a),
        .chan_b_data (chan_b),
        .order_sel   (order_sel),
        .sync_inv    (sync_inv),
        .read_mode   (read_mode),
        .conv_busy   (conv_busy),
        .start_req   (start_req),
        .sclk_o      (sclk_o),
        .sdata_o     (sdata_o),
        .sync_o      (sync_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Step to just after a rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: one start pulse, expected frame pushed to the scoreboard.
    task automatic send_now(input logic [SW-1:0] a, input logic [SW-1:0] b,
                            input logic ord, input string tag);
        exp_t e;
        tick();
        chan_a    = a;
        chan_b    = b;
        order_sel = ord;
        start_req = 1'b1;
        e.word  = ord ? {b, a} : {a, b};
        e.start = cyc + 1;
        e.tag   = tag;
        exp_q.push_back(e);
        frames_pushed++;
        tick();
        start_req = 1'b0;
    endtask

    task automatic wait_done();
        tick();
        while (exp_q.size() != 0 || mon_busy) tick();
        repeat (4) tick();
    endtask

    // Monitor: follows each frame and compares against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (sync_o !== sync_inv)) begin
                int            t0;
                int            sclk_bad;
                int            hold_bad;
                int            sync_bad;
                logic          held;
                logic [FB-1:0] got;
                exp_t          e;
                mon_busy = 1'b1;
                t0 = cyc;
                sclk_bad = 0;
                hold_bad = 0;
                sync_bad = 0;
                held = 1'b0;
                got = '0;
                for (int t = 0; t < FB * DIV; t++) begin
                    int  b;
                    int  ph;
                    logic exp_sclk;
                    logic exp_sync;
                    if (t > 0) @(negedge clk);
                    b  = t / DIV;
                    ph = t % DIV;
                    exp_sclk = (ph >= 1) && (ph <= DIV / 2);
                    if (sclk_o !== exp_sclk) sclk_bad++;
                    if (ph == 0) held = sdata_o;
                    else if (sdata_o !== held) hold_bad++;
                    if (ph == 1) got[FB-1-b] = sdata_o;
                    exp_sync = (b != SW) ^ sync_inv;
                    if (sync_o !== exp_sync) sync_bad++;
                end
                @(negedge clk);
                frames_seen++;
                check(sclk_o === 1'b0 && sdata_o === 1'b0, "R3",
                      "idle after frame sclk/sdata", {sclk_o, sdata_o}, 0);
                check(sync_o === sync_inv, sync_inv ? "R6" : "R5",
                      "sync idle level after frame", sync_o, sync_inv);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "frame without request", t0, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(got === e.word, "R2", "frame word", got, e.word);
                    check(t0 == e.start, e.tag, "launch cycle", t0, e.start);
                    check(sclk_bad == 0, "R3", "sclk shape errors", sclk_bad, 0);
                    check(hold_bad == 0, "R4", "data changes inside bit", hold_bad, 0);
                    check(sync_bad == 0, sync_inv ? "R6" : "R5",
                          "sync pattern errors", sync_bad, 0);
                end
                mon_busy = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(sclk_o === 1'b0 && sdata_o === 1'b0 && sync_o === 1'b0, "R1",
              "reset outputs", {sclk_o, sdata_o, sync_o}, 0);
        tick();
        rst_n = 1'b1;
        repeat (3) tick();
        @(negedge clk);
        check(sclk_o === 1'b0 && sync_o === 1'b0, "R1",
              "outputs after reset release", {sclk_o, sync_o}, 0);

        // R2 R5: channel A first, normal polarity.
        send_now(16'hA5C3, 16'h1E69, 1'b0, "R7");
        wait_done();

        // R2: channel B first.
        send_now(16'h8001, 16'h7FFE, 1'b1, "R7");
        wait_done();

        // R6: inverted sync, idle level checked before the frame.
        tick();
        sync_inv = 1'b1;
        @(negedge clk);
        check(sync_o === 1'b1, "R6", "inverted idle level", sync_o, 1);
        send_now(16'hFFFF, 16'h0000, 1'b0, "R7");
        wait_done();
        sync_inv = 1'b0;

        // R7: during-conversion mode launches while busy.
        tick();
        read_mode = 1'b1;
        conv_busy = 1'b1;
        send_now(16'h3C3C, 16'hC3C3, 1'b1, "R7");
        wait_done();

        // R8: after-conversion mode holds the request until busy drops.
        tick();
        read_mode = 1'b0;
        conv_busy = 1'b1;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        repeat (20) tick();
        check(frames_seen == frames_pushed && !mon_busy, "R8",
              "no frame while busy", frames_seen, frames_pushed);
        begin
            exp_t e;
            chan_a    = 16'h1234;
            chan_b    = 16'hFEDC;
            order_sel = 1'b0;
            conv_busy = 1'b0;
            e.word  = {16'h1234, 16'hFEDC};
            e.start = cyc + 1;
            e.tag   = "R8";
            exp_q.push_back(e);
            frames_pushed++;
        end
        wait_done();

        // R8: after-conversion mode with busy low launches at once.
        send_now(16'h0F0F, 16'hF0F0, 1'b0, "R8");
        wait_done();

        // R9 R10: restart request and data change in mid-frame.
        read_mode = 1'b1;
        send_now(16'h5A5A, 16'h9669, 1'b0, "R10");
        repeat (40) tick();
        start_req = 1'b1;
        chan_a    = 16'h0000;
        chan_b    = 16'hFFFF;
        order_sel = 1'b0;
        tick();
        start_req = 1'b0;
        wait_done();
        repeat (200) tick();
        check(frames_seen == frames_pushed, "R9",
              "frame count after mid-frame request", frames_seen, frames_pushed);

        finish_run();
    end

endmodule